// File: doc/BRIEF.md
# Downstream Cell Loopback Merger

This block returns ATM cells arriving from the ATM layer to the receive side of the cell interface. Each cell is 53 bytes. When the loop is enabled, an incoming cell is stored in a loop buffer that holds four whole cells. A transparency control decides whether the same cell also continues down the normal transmit-processing path. On the receive side, stored loop cells share one byte-wide output with cells from the normal output queue. Grants are made cell by cell, and the priority alternates whenever both sources have a cell waiting.

The block also drives a cell-available flag for the transmit side. While the loop is enabled, the flag is raised only when a whole cell fits both in the loop buffer and in the normal input buffer. The input buffer's free-cell count arrives as an input.

Every data interface is a valid/ready stream carrying one byte per transfer, with a start-of-cell strobe on the first byte. A byte moves on a clock edge where both valid and ready are high. A sender holds its byte and strobe steady while valid is high and ready is low. A sink may hold ready low for any length of time.

Top module: `dn_loop_merge`

## Requirements
- R1: With the loop enable at 0 when a cell begins, the cell is passed unchanged to the transmit-processing output and does not appear on the receive output.
- R2: With the loop enable at 1 and the transparency bit at 0 when a cell begins, the cell is stored in the loop buffer and does not appear on the transmit-processing output.
- R3: With the loop enable at 1 and the transparency bit at 1, the cell appears on both the transmit-processing output and, through the loop buffer, on the receive output.
- R4: The loop buffer holds at most 4 whole cells. With the buffer full and the loop enabled, the first byte of a new cell is not accepted.
- R5: The cell-available flag is 1 exactly when the input-buffer free count is nonzero and either the loop enable is 0 or the loop buffer has room for at least 53 more bytes.
- R6: When a loop cell and an output-queue cell are both waiting, the next grant goes to the source that was not granted most recently.
- R7: When only one source has a cell waiting, that source is granted without waiting for the other. With the loop disabled and the buffer empty, output-queue cells pass straight to the receive output.
- R8: Each cell on the receive output is 53 consecutive bytes from a single source. The start strobe is 1 on the first byte only, and no other cell's bytes are interleaved.
- R9: On either input, a byte offered between cells without the start strobe is accepted and discarded.
- R10: The loop enable and transparency settings are captured at a cell's first byte. A change during the cell has no effect on where that cell goes.
- R11: While the receive output is valid and its ready is low, the output byte and its strobe stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Downstream loop enable |
| loop_transp | input | 1 | 1: looped cells also go to transmit processing |
| ib_free_cells | input | IBF_W | Free whole-cell slots in the normal input buffer |
| tx_cell_avail | output | 1 | Transmit-side cell-available flag |
| atm_valid | input | 1 | Byte from ATM layer valid |
| atm_ready | output | 1 | Byte from ATM layer accepted |
| atm_data | input | DATA_W | Byte from ATM layer |
| atm_soc | input | 1 | Start of cell, ATM-layer input |
| ct_valid | output | 1 | Byte to transmit processing valid |
| ct_ready | input | 1 | Transmit processing accepts byte |
| ct_data | output | DATA_W | Byte to transmit processing |
| ct_soc | output | 1 | Start of cell, transmit-processing output |
| oq_valid | input | 1 | Output-queue byte valid |
| oq_ready | output | 1 | Output-queue byte accepted |
| oq_data | input | DATA_W | Output-queue byte |
| oq_soc | input | 1 | Start of cell, output-queue input |
| rx_valid | output | 1 | Receive-output byte valid |
| rx_ready | input | 1 | Receive side accepts byte |
| rx_data | output | DATA_W | Receive-output byte |
| rx_soc | output | 1 | Start of cell, receive output |

## Verification
The checker asserts properties that hold on every cycle. These are: the loop-cell count never exceeds its bound; the receive byte is held steady under back-pressure; only one start strobe is seen per receive cell; the cell-available flag drops whenever the input buffer is full; and the transmit-processing output is never valid without valid input. The bench keeps its own byte-level model of the loop-buffer fill and compares the cell-available flag against it every cycle. Some behaviours can only be shown by directed scenarios: the alternating grant order, the routing set by the enable and transparency bits, settings captured at the cell start, discarding of stray bytes, and refusal of a fifth cell.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic {SRC_OQ = 1'b0, SRC_LB = 1'b1} dl_src_e;

  // Cell-boundary pick: alternate when both wait, else take the one that waits.
  function automatic dl_src_e dl_pick(logic lb_wait, logic oq_wait, dl_src_e last);
    if (lb_wait && oq_wait) return (last == SRC_LB) ? SRC_OQ : SRC_LB;
    else if (lb_wait)       return SRC_LB;
    else                    return SRC_OQ;
  endfunction
endpackage

// File: rtl/dl_byte_fifo.sv
module dl_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 212,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  used
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   used <= used + CNT_W'(1);
        2'b01:   used <= used - CNT_W'(1);
        default: used <= used;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/dl_ingress_split.sv
module dl_ingress_split #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int FREE_W     = 8,
  localparam int IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              loop_transp,
  input  logic [FREE_W-1:0] lb_free,
  input  logic              atm_valid,
  output logic              atm_ready,
  input  logic [DATA_W-1:0] atm_data,
  input  logic              atm_soc,
  output logic              ct_valid,
  input  logic              ct_ready,
  output logic [DATA_W-1:0] ct_data,
  output logic              ct_soc,
  output logic              lb_wr_en,
  output logic [DATA_W-1:0] lb_wr_data,
  output logic              lb_cell_in
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] idx;
  logic             m_loop, m_transp;
  logic             at_start, stray, cur_loop, cur_transp, lb_room, to_ct, hs;

  always_comb begin
    at_start   = (idx == '0);
    stray      = at_start && !atm_soc;
    cur_loop   = at_start ? loop_en     : m_loop;
    cur_transp = at_start ? loop_transp : m_transp;
    lb_room    = !cur_loop || !at_start || (lb_free >= FREE_W'(CELL_BYTES));
    to_ct      = !cur_loop || cur_transp;
    ct_valid   = atm_valid && !stray && lb_room && to_ct;
    atm_ready  = stray || (lb_room && (!to_ct || ct_ready));
    hs         = atm_valid && atm_ready && !stray;
    lb_wr_en   = hs && cur_loop;
    lb_cell_in = lb_wr_en && (idx == LAST);
  end

  assign ct_data    = atm_data;
  assign ct_soc     = at_start;
  assign lb_wr_data = atm_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      m_loop   <= 1'b0;
      m_transp <= 1'b0;
    end else if (hs) begin
      if (at_start) begin
        m_loop   <= loop_en;
        m_transp <= loop_transp;
      end
      idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/dl_rx_arbiter.sv
module dl_rx_arbiter
  import dl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int LBC_W      = 3,
  localparam int IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LBC_W-1:0]  lb_cells,
  input  logic [DATA_W-1:0] lb_rd_data,
  output logic              lb_rd_en,
  output logic              lb_cell_out,
  input  logic              oq_valid,
  output logic              oq_ready,
  input  logic [DATA_W-1:0] oq_data,
  input  logic              oq_soc,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_soc
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  logic             busy;
  dl_src_e          src, last_src, pick;
  logic [IDX_W-1:0] idx;
  logic             lb_wait, oq_wait, hs;

  always_comb begin
    lb_wait     = (lb_cells != '0);
    oq_wait     = oq_valid && oq_soc;
    pick        = dl_pick(lb_wait, oq_wait, last_src);
    rx_valid    = busy && ((src == SRC_LB) || oq_valid);
    rx_data     = (src == SRC_LB) ? lb_rd_data : oq_data;
    rx_soc      = busy && (idx == '0);
    oq_ready    = busy ? ((src == SRC_OQ) && rx_ready) : (oq_valid && !oq_soc);
    lb_rd_en    = busy && (src == SRC_LB) && rx_ready;
    hs          = rx_valid && rx_ready;
    lb_cell_out = hs && (src == SRC_LB) && (idx == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      src      <= SRC_OQ;
      last_src <= SRC_OQ;
      idx      <= '0;
    end else if (!busy) begin
      if (lb_wait || oq_wait) begin
        busy     <= 1'b1;
        src      <= pick;
        last_src <= pick;
        idx      <= '0;
      end
    end else if (hs) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/dn_loop_merge.sv
module dn_loop_merge #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int LOOP_CELLS = 4,
  parameter int IBF_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              loop_transp,
  input  logic [IBF_W-1:0]  ib_free_cells,
  output logic              tx_cell_avail,
  input  logic              atm_valid,
  output logic              atm_ready,
  input  logic [DATA_W-1:0] atm_data,
  input  logic              atm_soc,
  output logic              ct_valid,
  input  logic              ct_ready,
  output logic [DATA_W-1:0] ct_data,
  output logic              ct_soc,
  input  logic              oq_valid,
  output logic              oq_ready,
  input  logic [DATA_W-1:0] oq_data,
  input  logic              oq_soc,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_soc
);
  localparam int LB_DEPTH = LOOP_CELLS * CELL_BYTES;
  localparam int LB_CNT_W = $clog2(LB_DEPTH + 1);
  localparam int LBC_W    = $clog2(LOOP_CELLS + 1);

  logic                lb_wr_en, lb_rd_en, lb_cell_in, lb_cell_out;
  logic [DATA_W-1:0]   lb_wr_data, lb_rd_data;
  logic [LB_CNT_W-1:0] lb_used, lb_free;
  logic [LBC_W-1:0]    lb_cells;

  assign lb_free = LB_CNT_W'(LB_DEPTH) - lb_used;

  dl_ingress_split #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .FREE_W(LB_CNT_W)) u_split (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .loop_transp(loop_transp),
    .lb_free(lb_free), .atm_valid(atm_valid), .atm_ready(atm_ready),
    .atm_data(atm_data), .atm_soc(atm_soc), .ct_valid(ct_valid), .ct_ready(ct_ready),
    .ct_data(ct_data), .ct_soc(ct_soc), .lb_wr_en(lb_wr_en), .lb_wr_data(lb_wr_data),
    .lb_cell_in(lb_cell_in)
  );

  dl_byte_fifo #(.DATA_W(DATA_W), .DEPTH(LB_DEPTH)) u_lbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(lb_wr_en), .wr_data(lb_wr_data),
    .rd_en(lb_rd_en), .rd_data(lb_rd_data), .used(lb_used)
  );

  // Whole cells ready for the receive side.
  always_ff @(posedge clk) begin
    if (!rst_n) lb_cells <= '0;
    else begin
      case ({lb_cell_in, lb_cell_out})
        2'b10:   lb_cells <= lb_cells + LBC_W'(1);
        2'b01:   lb_cells <= lb_cells - LBC_W'(1);
        default: lb_cells <= lb_cells;
      endcase
    end
  end

  dl_rx_arbiter #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .LBC_W(LBC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .lb_cells(lb_cells), .lb_rd_data(lb_rd_data),
    .lb_rd_en(lb_rd_en), .lb_cell_out(lb_cell_out), .oq_valid(oq_valid),
    .oq_ready(oq_ready), .oq_data(oq_data), .oq_soc(oq_soc), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_soc(rx_soc)
  );

  assign tx_cell_avail = (ib_free_cells != '0) &&
                         (!loop_en || (lb_free >= LB_CNT_W'(CELL_BYTES)));
endmodule

// File: rtl/dl_loop_chk.sv
module dl_loop_chk #(
  parameter int DATA_W = 8,
  parameter int IBF_W  = 4,
  parameter int LBC_W  = 3,
  parameter int CELLS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_soc,
  input logic              tx_cell_avail,
  input logic [IBF_W-1:0]  ib_free_cells,
  input logic [LBC_W-1:0]  lb_cells,
  input logic              ct_valid,
  input logic              atm_valid
);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lb_cells <= LBC_W'(CELLS));

  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_soc)));

  a_r8_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_soc) |=> !rx_soc);

  a_r5_ib_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cell_avail |-> (ib_free_cells != '0));

  a_r1_ct_from_atm: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid |-> atm_valid);
endmodule

bind dn_loop_merge dl_loop_chk #(
  .DATA_W(DATA_W), .IBF_W(IBF_W), .LBC_W(LBC_W), .CELLS(LOOP_CELLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_soc(rx_soc), .tx_cell_avail(tx_cell_avail),
  .ib_free_cells(ib_free_cells), .lb_cells(lb_cells), .ct_valid(ct_valid),
  .atm_valid(atm_valid)
);

// File: tb/sim_dn_loop_merge.sv
`timescale 1ns/1ps
module sim_dn_loop_merge;
  localparam int CB = 53, CELLS = 4, DEPTH = CB * CELLS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, loop_en = 1'b0, loop_transp = 1'b0;
  logic [3:0] ib_free_cells = 4'd2;
  logic       tx_cell_avail;
  logic       atm_valid = 1'b0, atm_ready, atm_soc = 1'b0;
  logic [7:0] atm_data = '0;
  logic       ct_valid, ct_ready = 1'b1, ct_soc;
  logic [7:0] ct_data;
  logic       oq_valid = 1'b0, oq_ready, oq_soc = 1'b0;
  logic [7:0] oq_data = '0;
  logic       rx_valid, rx_ready = 1'b1, rx_soc;
  logic [7:0] rx_data;

  dn_loop_merge u0 (.*);

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: loop-buffer byte fill plus captured cells per output.
  int  m_lb_bytes = 0, m_atm_idx = 0;
  bit  m_loop = 0, rx_from_lb = 0;
  int  rx_cur[$], ct_cur[$], rx_got[$], ct_got[$];

  task automatic close_cell(string req, ref int cur[$], ref int got[$]);
    for (int i = 0; i < CB; i++)
      if (cur[i] != ((cur[0] + i) & 8'hFF)) chk(0, req, cur[i], (cur[0] + i) & 8'hFF);
    chk(1, req, 0, 0);
    got.push_back(cur[0]);
    cur.delete();
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tx_cell_avail == ((ib_free_cells != 0) && (!loop_en || (DEPTH - m_lb_bytes) >= CB)),
        "R5", tx_cell_avail, -1);
    if (atm_valid && atm_ready) begin
      if (m_atm_idx == 0) begin
        if (atm_soc) begin
          m_loop = loop_en;
          m_atm_idx = 1;
          if (m_loop) m_lb_bytes++;
        end
      end else begin
        if (m_loop) m_lb_bytes++;
        m_atm_idx = (m_atm_idx == CB - 1) ? 0 : m_atm_idx + 1;
      end
    end
    if (rx_valid && rx_ready) begin
      if (rx_soc != (rx_cur.size() == 0)) chk(0, "R8", rx_soc, rx_cur.size() == 0);
      if (rx_cur.size() == 0) rx_from_lb = (rx_data < 8'h80);
      if (rx_from_lb) m_lb_bytes--;
      rx_cur.push_back(rx_data);
      if (rx_cur.size() == CB) close_cell("R8", rx_cur, rx_got);
    end
    if (ct_valid && ct_ready) begin
      if (ct_soc != (ct_cur.size() == 0)) chk(0, "R1", ct_soc, ct_cur.size() == 0);
      ct_cur.push_back(ct_data);
      if (ct_cur.size() == CB) close_cell("R1", ct_cur, ct_got);
    end
  end

  task automatic wait_atm();
    forever begin @(negedge clk); if (atm_ready) break; end
    @(posedge clk); #1;
  endtask
  task automatic wait_oq();
    forever begin @(negedge clk); if (oq_ready) break; end
    @(posedge clk); #1;
  endtask

  task automatic send_atm(int tag, int stray = 0, int flip_at = -1);
    for (int s = 0; s < stray; s++) begin
      atm_valid = 1; atm_soc = 0; atm_data = 8'hEE; wait_atm();
    end
    for (int i = 0; i < CB; i++) begin
      atm_valid = 1; atm_soc = (i == 0); atm_data = 8'((tag + i) & 8'hFF);
      if (i == flip_at) loop_en = ~loop_en;
      wait_atm();
    end
    atm_valid = 0; atm_soc = 0;
  endtask

  task automatic send_oq(int tag, int stray = 0);
    for (int s = 0; s < stray; s++) begin
      oq_valid = 1; oq_soc = 0; oq_data = 8'h11; wait_oq();
    end
    for (int i = 0; i < CB; i++) begin
      oq_valid = 1; oq_soc = (i == 0); oq_data = 8'((tag + i) & 8'hFF);
      wait_oq();
    end
    oq_valid = 0; oq_soc = 0;
  endtask

  task automatic settle(); repeat (300) @(posedge clk); #1; endtask

  task automatic chk_q(string req, int got[$], int exp[$]);
    chk(got.size() == exp.size(), req, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++) chk(got[i] == exp[i], req, got[i], exp[i]);
  endtask

  task automatic clear_q(); rx_got.delete(); ct_got.delete(); endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(rx_valid == 0, "R8 reset", rx_valid, 0);
    chk(ct_valid == 0, "R1 reset", ct_valid, 0);
    chk(tx_cell_avail == 1, "R5 reset", tx_cell_avail, 1);
    @(posedge clk); #1;

    // R1: loop off, straight to transmit processing
    send_atm(8'h01); settle();
    chk_q("R1 ct", ct_got, '{8'h01}); chk_q("R1 rx", rx_got, '{}); clear_q();

    // R2, R4, R5: non-transparent, fill the buffer while receive side stalls
    loop_en = 1; loop_transp = 0; rx_ready = 0;
    send_atm(8'h10); send_atm(8'h11); send_atm(8'h12); send_atm(8'h13);
    @(negedge clk);
    chk(tx_cell_avail == 0, "R5 full", tx_cell_avail, 0);
    @(posedge clk); #1;
    atm_valid = 1; atm_soc = 1; atm_data = 8'h14;
    repeat (6) begin
      @(negedge clk);
      chk(atm_ready == 0 && ct_valid == 0, "R4 fifth cell", atm_ready, 0);
    end
    @(posedge clk); #1 atm_valid = 0; atm_soc = 0;
    loop_en = 0;
    @(negedge clk);
    chk(tx_cell_avail == 1, "R5 loop off", tx_cell_avail, 1);
    @(posedge clk); #1 loop_en = 1; rx_ready = 1;
    settle();
    chk_q("R2 rx", rx_got, '{8'h10, 8'h11, 8'h12, 8'h13}); chk_q("R2 ct", ct_got, '{}); clear_q();

    // R3: transparent
    loop_transp = 1; send_atm(8'h20); settle();
    chk_q("R3 ct", ct_got, '{8'h20}); chk_q("R3 rx", rx_got, '{8'h20}); clear_q();

    // R6, R11: both sources wait, receive side stalls then releases
    loop_transp = 0; rx_ready = 0;
    send_atm(8'h30); send_atm(8'h31);
    fork
      begin send_oq(8'h90); send_oq(8'h91); end
      begin repeat (20) @(posedge clk); #1 rx_ready = 1; end
    join
    settle();
    chk_q("R6 order", rx_got, '{8'h30, 8'h90, 8'h31, 8'h91}); clear_q();

    // R7, R9: output queue alone with loop off, stray bytes on both inputs
    loop_en = 0;
    send_oq(8'h95); settle();
    chk_q("R7 rx", rx_got, '{8'h95}); clear_q();
    send_oq(8'h96, 2); settle();
    chk_q("R9 oq stray", rx_got, '{8'h96}); clear_q();
    send_atm(8'h05, 3); settle();
    chk_q("R9 atm stray", ct_got, '{8'h05}); chk_q("R9 atm rx", rx_got, '{}); clear_q();

    // R10: enable flipped mid-cell
    send_atm(8'h06, 0, 10); settle();
    chk_q("R10 ct", ct_got, '{8'h06}); chk_q("R10 rx", rx_got, '{}); clear_q();
    loop_en = 0;

    // R5: input buffer full
    ib_free_cells = 0;
    @(negedge clk);
    chk(tx_cell_avail == 0, "R5 ib full", tx_cell_avail, 0);
    @(posedge clk); #1 ib_free_cells = 2;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule